// File: doc/BRIEF.md
# Mesh-to-Core Ingress Framer

This block sits between one port of a mesh router and the processing engine of the same tile. Flits arrive from the router into a 16-entry queue, with no handshake back to the sender. The block drains the queue at one flit per cycle and sends each flit to one of two independent packet parsers, chosen by a lane bit in the flit. Packets on lane 0 carry data. Their payload is grouped into 64-bit words and written to data memory. Packets on lane 1 carry instructions. Their payload is grouped into 96-bit words and written to instruction memory. The two lanes may interleave at flit granularity.

Every packet opens with a header flit. The second flit is a control flit, which carries:
- a base address for the memory words that follow;
- an optional new-program-counter command, with a start address and an execute-enable;
- sleep and wake commands for the whole processing engine.

The core's own stores into data memory have priority over network writes. A completed data word waits in a holding register while the core is storing, and the queue stops draining during that time. When the final word of a data packet is written while the core waits for data, the block raises a one-cycle break pulse so the core can resume.

Top module: `noc_core_ingress`

## Requirements
- R1: Flits presented with `flit_valid` are stored in a 16-entry queue and leave it in arrival order, at most one per cycle, without loss while the queue is not full.
- R2: `almost_full` is high exactly while the queue holds 12 or more flits.
- R3: Flit layout: bits [31:0] are the payload, bit 32 is the lane (0 = data, 1 = instruction), bit 33 marks a header and bit 34 marks the last flit of a packet. Each lane keeps its own packet state, so the flits of two packets on different lanes may alternate one by one.
- R4: On lane 0, every two payload flits form one 64-bit word, with the first flit in bits [31:0]. The words are written to data memory at the base address and then at consecutive addresses.
- R5: On lane 1, every three payload flits form one 96-bit word, with the first flit in the lowest 32 bits. The words are written to instruction memory at the base address and then at consecutive addresses.
- R6: `dm_we` is never high in a cycle where `core_st` is high. A completed data word is held, and the queue stops draining, until the core store ends. No data is lost.
- R7: Control flit fields: bit 0 is the new-program-counter flag, bit 1 is execute-enable, bits [13:4] are the start address and bits [25:16] are the memory base address. With the flag set, `pc_load` pulses for one cycle, `pc_addr` takes the start address and `run_en` takes the execute-enable bit. With the flag clear, `pc_addr` and `run_en` keep their values.
- R8: Control flit bit 2 sets `pe_sleep` and bit 3 clears it. When both are set, wake wins. When neither is set, the state is kept.
- R9: `brk` pulses for one cycle, in the cycle after the final data word of a lane-0 packet is written, if `core_wfd` was high during that write. It does not pulse in any other case.
- R10: If a packet ends partway through a word, that partial word is discarded and `frag_err` is set. `frag_err` stays set until reset.
- R11: During and directly after reset, all write strobes, `pc_load`, `brk`, `run_en`, `pe_sleep`, `frag_err` and `almost_full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flit_valid | input | 1 | A flit is presented this cycle |
| flit_in | input | 38 | Incoming flit |
| almost_full | output | 1 | Queue occupancy at or above threshold |
| core_st | input | 1 | Core store to data memory in this cycle |
| core_wfd | input | 1 | Core is stalled waiting for data |
| dm_we | output | 1 | Data memory write strobe |
| dm_addr | output | 10 | Data memory word address |
| dm_wdata | output | 64 | Data memory write word |
| im_we | output | 1 | Instruction memory write strobe |
| im_addr | output | 10 | Instruction memory word address |
| im_wdata | output | 96 | Instruction memory write word |
| pc_load | output | 1 | One-cycle start-execution command |
| pc_addr | output | 10 | Start address for execution |
| run_en | output | 1 | Execute-enable level |
| pe_sleep | output | 1 | Processing engine sleep state |
| brk | output | 1 | Release pulse for a core waiting on data |
| frag_err | output | 1 | Sticky partial-word error |

## Verification
The framing is swept over data packets of one to four words and instruction packets of one to three words. Each payload value encodes its lane, address and beat, so a swapped half, a wrong stride or an off-by-one base shows up as a mismatched word. A packet whose lanes alternate flit by flit shows whether the two parsers really keep separate state. A data packet held back by a long core store drives the occupancy through the threshold one flit at a time, which pins down `almost_full` and the stall. The sleep, wake, program-counter and fragment cases each step through every combination of their bits and compare the result with the previous state.

// File: rtl/noc_ingress_pkg.sv
package noc_ingress_pkg;
  localparam int PAY_W   = 32;
  localparam int LANE_B  = 32;
  localparam int HEAD_B  = 33;
  localparam int TAIL_B  = 34;
  localparam int NPC_B   = 0;
  localparam int EXEC_B  = 1;
  localparam int SLEEP_B = 2;
  localparam int WAKE_B  = 3;
  localparam int PC_LSB  = 4;
  localparam int BASE_LSB = 16;
  localparam logic LANE_DATA  = 1'b0;
  localparam logic LANE_INSTR = 1'b1;

  typedef enum logic [1:0] {FR_IDLE, FR_CTRL, FR_BODY} fr_state_e;
endpackage

// File: rtl/flit_queue.sv
module flit_queue #(
  parameter int WIDTH    = 38,
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 12,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic             almost_full,
  output logic [CW-1:0]    level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout        = mem[rd_ptr];
  assign empty       = (count == '0);
  assign full        = (count == CW'(DEPTH));
  assign almost_full = (count >= CW'(AF_LEVEL));
  assign level       = count;
endmodule

// File: rtl/lane_framer.sv
module lane_framer
  import noc_ingress_pkg::*;
#(
  parameter int BEATS  = 2,
  parameter int ADDR_W = 10,
  localparam int OW    = BEATS * PAY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              head,
  input  logic              tail,
  input  logic [PAY_W-1:0]  payload,
  output logic              ctrl_hit,
  output logic              word_done,
  output logic [OW-1:0]     word_data,
  output logic [ADDR_W-1:0] word_addr,
  output logic              word_last,
  output logic              frag_p
);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

  fr_state_e                   st;
  logic [BW-1:0]               beat;
  logic [ADDR_W-1:0]           addr;
  logic [BEATS-2:0][PAY_W-1:0] acc;
  logic                        body, at_end;

  assign ctrl_hit  = fire && !head && (st == FR_CTRL);
  assign body      = fire && !head && (st == FR_BODY);
  assign at_end    = (beat == BW'(BEATS - 1));
  assign word_done = body && at_end;
  assign word_last = word_done && tail;
  assign frag_p    = body && tail && !at_end;
  assign word_addr = addr;

  always_comb begin
    word_data = '0;
    for (int g = 0; g < BEATS - 1; g++) word_data[g*PAY_W +: PAY_W] = acc[g];
    word_data[(BEATS-1)*PAY_W +: PAY_W] = payload;
  end

  always_ff @(posedge clk) begin
    if (body && !at_end) acc[beat] <= payload;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= FR_IDLE;
      beat <= '0;
      addr <= '0;
    end else if (fire) begin
      if (head) begin
        st   <= tail ? FR_IDLE : FR_CTRL;
        beat <= '0;
      end else begin
        case (st)
          FR_CTRL: begin
            addr <= payload[BASE_LSB +: ADDR_W];
            beat <= '0;
            st   <= tail ? FR_IDLE : FR_BODY;
          end
          FR_BODY: begin
            if (at_end) begin
              beat <= '0;
              addr <= addr + 1'b1;
            end else begin
              beat <= beat + 1'b1;
            end
            if (tail) st <= FR_IDLE;
          end
          default: st <= FR_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/noc_core_ingress.sv
module noc_core_ingress
  import noc_ingress_pkg::*;
#(
  parameter int FLIT_W   = 38,
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 12,
  parameter int ADDR_W   = 10,
  parameter int DW_BEATS = 2,
  parameter int IW_BEATS = 3,
  localparam int DW_W    = DW_BEATS * PAY_W,
  localparam int IW_W    = IW_BEATS * PAY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flit_valid,
  input  logic [FLIT_W-1:0] flit_in,
  output logic              almost_full,
  input  logic              core_st,
  input  logic              core_wfd,
  output logic              dm_we,
  output logic [ADDR_W-1:0] dm_addr,
  output logic [DW_W-1:0]   dm_wdata,
  output logic              im_we,
  output logic [ADDR_W-1:0] im_addr,
  output logic [IW_W-1:0]   im_wdata,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_addr,
  output logic              run_en,
  output logic              pe_sleep,
  output logic              brk,
  output logic              frag_err
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [FLIT_W-1:0] hd;
  logic              q_empty, q_full, pop;
  logic [CW-1:0]     q_level;
  logic [PAY_W-1:0]  cw;
  logic              fire_d, fire_i, ctrl_any;

  logic              ch_d, done_d, last_d, fe_d;
  logic [DW_W-1:0]   wd_d;
  logic [ADDR_W-1:0] wa_d;
  logic              ch_i, done_i, last_i, fe_i;
  logic [IW_W-1:0]   wd_i;
  logic [ADDR_W-1:0] wa_i;

  logic              dpend, dlast;
  logic [DW_W-1:0]   dword;
  logic [ADDR_W-1:0] daddr;
  logic              spare_unused;

  flit_queue #(.WIDTH(FLIT_W), .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) u_queue (
    .clk(clk), .rst(rst), .push(flit_valid), .din(flit_in), .pop(pop),
    .dout(hd), .empty(q_empty), .full(q_full), .almost_full(almost_full),
    .level(q_level)
  );

  assign pop    = !q_empty && !(dpend && core_st);
  assign fire_d = pop && (hd[LANE_B] == LANE_DATA);
  assign fire_i = pop && (hd[LANE_B] == LANE_INSTR);
  assign cw     = hd[PAY_W-1:0];
  assign spare_unused = ^{hd[FLIT_W-1:TAIL_B+1], q_full, last_i};

  lane_framer #(.BEATS(DW_BEATS), .ADDR_W(ADDR_W)) u_data_lane (
    .clk(clk), .rst(rst), .fire(fire_d), .head(hd[HEAD_B]), .tail(hd[TAIL_B]),
    .payload(cw), .ctrl_hit(ch_d), .word_done(done_d), .word_data(wd_d),
    .word_addr(wa_d), .word_last(last_d), .frag_p(fe_d)
  );

  lane_framer #(.BEATS(IW_BEATS), .ADDR_W(ADDR_W)) u_instr_lane (
    .clk(clk), .rst(rst), .fire(fire_i), .head(hd[HEAD_B]), .tail(hd[TAIL_B]),
    .payload(cw), .ctrl_hit(ch_i), .word_done(done_i), .word_data(wd_i),
    .word_addr(wa_i), .word_last(last_i), .frag_p(fe_i)
  );

  assign ctrl_any = ch_d || ch_i;

  // control-flit decode
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_load  <= 1'b0;
      pc_addr  <= '0;
      run_en   <= 1'b0;
      pe_sleep <= 1'b0;
    end else begin
      pc_load <= ctrl_any && cw[NPC_B];
      if (ctrl_any && cw[NPC_B]) begin
        pc_addr <= cw[PC_LSB +: ADDR_W];
        run_en  <= cw[EXEC_B];
      end
      if (ctrl_any) begin
        if (cw[WAKE_B])       pe_sleep <= 1'b0;
        else if (cw[SLEEP_B]) pe_sleep <= 1'b1;
      end
    end
  end

  // data word holding stage, yields to core stores
  always_ff @(posedge clk) begin
    if (rst) begin
      dpend <= 1'b0;
      dlast <= 1'b0;
      daddr <= '0;
      dword <= '0;
      brk   <= 1'b0;
    end else begin
      if (done_d) begin
        dpend <= 1'b1;
        dlast <= last_d;
        daddr <= wa_d;
        dword <= wd_d;
      end else if (dm_we) begin
        dpend <= 1'b0;
      end
      brk <= dm_we && dlast && core_wfd;
    end
  end

  assign dm_we    = dpend && !core_st;
  assign dm_addr  = daddr;
  assign dm_wdata = dword;

  // instruction word write stage
  always_ff @(posedge clk) begin
    if (rst) begin
      im_we    <= 1'b0;
      im_addr  <= '0;
      im_wdata <= '0;
      frag_err <= 1'b0;
    end else begin
      im_we <= done_i;
      if (done_i) begin
        im_addr  <= wa_i;
        im_wdata <= wd_i;
      end
      frag_err <= frag_err || fe_d || fe_i;
    end
  end
endmodule

// File: rtl/noc_core_ingress_chk.sv
module noc_core_ingress_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          core_st,
  input logic          core_wfd,
  input logic          dm_we,
  input logic          im_we,
  input logic          brk,
  input logic          frag_err,
  input logic [CW-1:0] q_level
);
  p_cap_r1: assert property (@(posedge clk) disable iff (rst)
    q_level <= CW'(DEPTH));

  p_store_wins_r6: assert property (@(posedge clk) disable iff (rst)
    core_st |-> !dm_we);

  p_im_gap_r5: assert property (@(posedge clk) disable iff (rst)
    im_we |=> !im_we);

  p_brk_cause_r9: assert property (@(posedge clk) disable iff (rst)
    brk |-> $past(dm_we && core_wfd));

  p_brk_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    brk |=> !brk);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    frag_err |=> frag_err);
endmodule

bind noc_core_ingress noc_core_ingress_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .core_st(core_st), .core_wfd(core_wfd),
  .dm_we(dm_we), .im_we(im_we), .brk(brk), .frag_err(frag_err),
  .q_level(q_level)
);

// File: tb/test_noc_core_ingress.sv
module test_noc_core_ingress;
  logic        clk = 1'b0;
  logic        rst;
  logic        flit_valid;
  logic [37:0] flit_in;
  logic        almost_full, core_st, core_wfd;
  logic        dm_we, im_we, pc_load, run_en, pe_sleep, brk, frag_err;
  logic [9:0]  dm_addr, im_addr, pc_addr;
  logic [63:0] dm_wdata;
  logic [95:0] im_wdata;

  always #2 clk = ~clk;

  noc_core_ingress i_noc_core_ingress (
    .clk(clk), .rst(rst), .flit_valid(flit_valid), .flit_in(flit_in),
    .almost_full(almost_full), .core_st(core_st), .core_wfd(core_wfd),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .im_we(im_we), .im_addr(im_addr), .im_wdata(im_wdata),
    .pc_load(pc_load), .pc_addr(pc_addr), .run_en(run_en),
    .pe_sleep(pe_sleep), .brk(brk), .frag_err(frag_err)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [63:0] dmem [1024];
  logic [95:0] imem [1024];
  int dm_cnt = 0, im_cnt = 0, brk_cnt = 0, pc_cnt = 0, clash = 0;
  logic [9:0] last_pc = '0;

  always @(posedge clk) begin
    if (!rst) begin
      if (dm_we) begin dmem[dm_addr] <= dm_wdata; dm_cnt <= dm_cnt + 1; end
      if (dm_we && core_st) clash <= clash + 1;
      if (im_we) begin imem[im_addr] <= im_wdata; im_cnt <= im_cnt + 1; end
      if (brk) brk_cnt <= brk_cnt + 1;
      if (pc_load) begin pc_cnt <= pc_cnt + 1; last_pc <= pc_addr; end
    end
  end

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pay(int l, int a, int b);
    return {4'(b), 3'b0, 1'(l), 8'h3C, 6'b0, 10'(a)};
  endfunction

  function automatic logic [31:0] ctrl(bit npc, bit ex, bit sl, bit wk, int pc, int base);
    return {6'b0, 10'(base), 2'b0, 10'(pc), wk, sl, ex, npc};
  endfunction

  // flit i of a packet: header, control, then n payload flits
  function automatic logic [37:0] mkflit(int l, int i, int n, int base, logic [31:0] cw);
    int w = (l == 1) ? 3 : 2;
    if (i == 0) return {3'b0, 1'b0, 1'b1, 1'(l), 32'h0};
    if (i == 1) return {3'b0, 1'(n == 0), 1'b0, 1'(l), cw};
    return {3'b0, 1'(i - 2 == n - 1), 1'b0, 1'(l), pay(l, base + (i - 2) / w, (i - 2) % w)};
  endfunction

  task automatic put(input logic [37:0] f);
    flit_valid = 1'b1;
    flit_in    = f;
    @(negedge clk);
    flit_valid = 1'b0;
  endtask

  task automatic send_pkt(int l, logic [31:0] cw, int n, int base);
    for (int i = 0; i < n + 2; i++) put(mkflit(l, i, n, base, cw));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d0, b0, i0, p0;
    bit sl_exp;
    rst = 1'b1; flit_valid = 1'b0; flit_in = '0; core_st = 1'b0; core_wfd = 1'b0;
    idle(3);
    rst = 1'b0;
    // R11: reset state
    check({dm_we, im_we, pc_load, brk, run_en, pe_sleep, frag_err, almost_full} == 8'h0,
          "R11 reset outputs", {dm_we, im_we, pc_load, brk, run_en, pe_sleep, frag_err, almost_full}, 0);
    idle(2);

    // R4 / R9: data packets of 1..4 words, with and without a waiting core
    for (int nw = 1; nw <= 4; nw++) begin
      for (int wf = 0; wf < 2; wf++) begin
        int base = 16 * nw + 100 * wf;
        d0 = dm_cnt; b0 = brk_cnt;
        core_wfd = 1'(wf);
        send_pkt(0, ctrl(0, 0, 0, 0, 0, base), 2 * nw, base);
        idle(8);
        check(dm_cnt - d0 == nw, "R4 data word count", dm_cnt - d0, nw);
        for (int w = 0; w < nw; w++)
          check(dmem[base + w] == {pay(0, base + w, 1), pay(0, base + w, 0)}, "R4 data word",
                dmem[base + w], {pay(0, base + w, 1), pay(0, base + w, 0)});
        check(brk_cnt - b0 == wf, "R9 break count", brk_cnt - b0, wf);
        core_wfd = 1'b0;
      end
    end

    // R5: instruction packets of 1..3 words
    for (int nw = 1; nw <= 3; nw++) begin
      int base = 200 + 8 * nw;
      i0 = im_cnt;
      send_pkt(1, ctrl(0, 0, 0, 0, 0, base), 3 * nw, base);
      idle(8);
      check(im_cnt - i0 == nw, "R5 instr word count", im_cnt - i0, nw);
      for (int w = 0; w < nw; w++)
        check(imem[base + w] == {pay(1, base + w, 2), pay(1, base + w, 1), pay(1, base + w, 0)},
              "R5 instr word", imem[base + w],
              {pay(1, base + w, 2), pay(1, base + w, 1), pay(1, base + w, 0)});
    end

    // R3: flit-by-flit interleaving of a data and an instruction packet
    d0 = dm_cnt; i0 = im_cnt;
    for (int i = 0; i < 8; i++) begin
      if (i < 6) put(mkflit(0, i, 4, 300, ctrl(0, 0, 0, 0, 0, 300)));
      put(mkflit(1, i, 6, 400, ctrl(0, 0, 0, 0, 0, 400)));
    end
    idle(10);
    check(dm_cnt - d0 == 2 && im_cnt - i0 == 2, "R3 interleave counts", {dm_cnt - d0, im_cnt - i0}, {32'd2, 32'd2});
    for (int w = 0; w < 2; w++) begin
      check(dmem[300 + w] == {pay(0, 300 + w, 1), pay(0, 300 + w, 0)}, "R3 data lane word",
            dmem[300 + w], {pay(0, 300 + w, 1), pay(0, 300 + w, 0)});
      check(imem[400 + w] == {pay(1, 400 + w, 2), pay(1, 400 + w, 1), pay(1, 400 + w, 0)},
            "R3 instr lane word", imem[400 + w],
            {pay(1, 400 + w, 2), pay(1, 400 + w, 1), pay(1, 400 + w, 0)});
    end

    // R7: new program counter handling
    p0 = pc_cnt;
    send_pkt(1, ctrl(1, 1, 0, 0, 10'h155, 500), 0, 500); idle(6);
    check(pc_cnt - p0 == 1 && last_pc == 10'h155 && run_en, "R7 start load",
          {pc_cnt - p0, 22'(last_pc), 1'(run_en)}, {32'd1, 22'h155, 1'b1});
    p0 = pc_cnt;
    send_pkt(0, ctrl(0, 0, 0, 0, 10'h2AA, 500), 0, 500); idle(6);
    check(pc_cnt == p0 && pc_addr == 10'h155 && run_en, "R7 flag clear keeps state",
          {pc_cnt - p0, 22'(pc_addr), 1'(run_en)}, {32'd0, 22'h155, 1'b1});
    send_pkt(0, ctrl(1, 0, 0, 0, 10'h0AB, 500), 0, 500); idle(6);
    check(last_pc == 10'h0AB && !run_en, "R7 reload with execute off",
          {22'(last_pc), 1'(run_en)}, {22'h0AB, 1'b0});

    // R8: sleep / wake over all bit combinations
    sl_exp = 1'b0;
    for (int i = 0; i < 8; i++) begin
      bit sl = 1'(i[0] ^ i[2]);
      bit wk = 1'(i[1]);
      send_pkt(i % 2, ctrl(0, 0, sl, wk, 0, 0), 0, 0); idle(4);
      sl_exp = wk ? 1'b0 : (sl ? 1'b1 : sl_exp);
      check(pe_sleep == sl_exp, "R8 sleep state", pe_sleep, sl_exp);
    end

    // R6 / R2 / R1: long core store holds a word and backs up the queue
    core_st = 1'b1;
    d0 = dm_cnt;
    for (int k = 1; k <= 18; k++) begin
      int occ;
      put(mkflit(0, k - 1, 16, 600, ctrl(0, 0, 0, 0, 0, 600)));
      occ = k - ((k - 1 < 4) ? k - 1 : 4);
      check(almost_full == (occ >= 12), "R2 threshold", almost_full, occ >= 12);
    end
    idle(3);
    check(dm_cnt == d0, "R6 no write during core store", dm_cnt - d0, 0);
    core_st = 1'b0;
    idle(25);
    check(dm_cnt - d0 == 8 && clash == 0, "R6 held words released", {dm_cnt - d0, clash}, {32'd8, 32'd0});
    for (int w = 0; w < 8; w++)
      check(dmem[600 + w] == {pay(0, 600 + w, 1), pay(0, 600 + w, 0)}, "R1 order after backlog",
            dmem[600 + w], {pay(0, 600 + w, 1), pay(0, 600 + w, 0)});
    check(!almost_full, "R2 drained", almost_full, 0);

    // R10: packet ending mid-word
    check(!frag_err, "R10 no error before fragment", frag_err, 0);
    d0 = dm_cnt; b0 = brk_cnt;
    core_wfd = 1'b1;
    send_pkt(0, ctrl(0, 0, 0, 0, 0, 700), 3, 700); idle(8);
    check(dm_cnt - d0 == 1 && frag_err && brk_cnt == b0, "R10 partial word dropped",
          {dm_cnt - d0, 1'(frag_err), brk_cnt - b0}, {32'd1, 1'b1, 32'd0});
    core_wfd = 1'b0;
    send_pkt(1, ctrl(0, 0, 0, 0, 0, 710), 3, 710); idle(8);
    check(frag_err, "R10 error sticky", frag_err, 1);
    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    check(!frag_err && !pe_sleep && !run_en, "R11 reset clears state",
          {frag_err, pe_sleep, run_en}, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule